// File: doc/BRIEF.md
# Serial Flash Status and Write Guard

This block keeps the eight-bit status word of a serial flash memory and decides, for every command decoded by the serial front end, whether the command may act. It holds the busy flag, the write enable latch, a three-bit protection level and a lock bit for status writes. It weighs the protection level against the target address, the lock bit against the write-protect pin, and the latch against the command kind. Then it tells the front end in the same cycle whether the command is granted.

An accepted status write, page program, sector erase or bulk erase starts an internal busy counter, loaded from a programmable cycle count, which stands in for the array's write time. While the counter runs, only status reads are granted. When it expires, the busy flag and the write enable latch drop together. The array contents and the serial bit framing belong to other blocks.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status word is 00h. Its layout is: bit 0 busy, bit 1 write enable latch, bits 4:2 protection level, bits 6:5 read as 0, bit 7 status-write lock.
- R2: Command codes on `cmd_op` are 0 none, 1 write enable, 2 write disable, 3 status read, 4 status write, 5 page program, 6 sector erase, 7 bulk erase. Write enable sets the latch and write disable clears it. Code 0 is never granted.
- R3: A granted status write copies `cmd_wdata[4:2]` into the protection level and `cmd_wdata[7]` into the lock bit. Bits 6:5, 1 and 0 of `cmd_wdata` have no effect.
- R4: Status write, page program, sector erase and bulk erase are refused while the write enable latch is 0, and a refused command leaves the status word unchanged.
- R5: The protected region grows down from the top of the 512 KB array, which is split into eight 64 KB sectors, with sector n starting at n×10000h. Level 0 protects nothing, level 1 protects sector 7, level 2 protects sectors 6–7, level 3 protects sectors 4–7, and levels 4–7 protect all sectors.
- R6: A status write is refused when the lock bit is 1 and `wp_n` is low. It is granted when `wp_n` is high.
- R7: A page program or sector erase whose address falls in a protected sector is refused. One whose address falls in an unprotected sector is granted.
- R8: Bulk erase is refused whenever the protection level is nonzero.
- R9: A granted modify command raises the busy bit for `busy_cycles` clock cycles after the accepting edge, with 0 treated as 1. On the edge where the busy bit drops, the write enable latch also clears.
- R10: While busy, every command except status read is refused and changes nothing. A status read is granted.
- R11: `grant` is combinational: it reflects the command presented in the same cycle, before the clock edge that acts on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A decoded command is presented this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | 19 | Byte address for program and sector erase |
| cmd_wdata | input | 8 | Data byte for status write |
| wp_n | input | 1 | Write-protect pin, active low |
| busy_cycles | input | 16 | Length of the internal write time, in cycles |
| grant | output | 1 | The presented command is allowed to act |
| status | output | 8 | Current status word |

## Verification
The hardest state to reach is a command arriving while the busy counter is still running. With a one-cycle write time that window is a single cycle, and the table walk hardly touches it. The directed part therefore loads a five-cycle write time, accepts a status write, and spends the busy window offering a status write that would change the protection level, a write disable and a status read. It then checks that the latch and level are untouched until the exact edge where busy and the latch drop together. A zero write time is checked separately to confirm it behaves as one cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WEN   = 3'd1,
    OP_WDIS  = 3'd2,
    OP_RSTAT = 3'd3,
    OP_WSTAT = 3'd4,
    OP_PROG  = 3'd5,
    OP_SERA  = 3'd6,
    OP_BERA  = 3'd7
  } fsg_op_e;

  function automatic logic is_modify(input fsg_op_e op);
    return (op == OP_WSTAT) || (op == OP_PROG) || (op == OP_SERA) || (op == OP_BERA);
  endfunction
endpackage

// File: rtl/fsg_zone.sv
module fsg_zone #(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 16
) (
  input  logic [2:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              sect_locked,
  output logic              any_locked
);
  localparam int IDX_W = ADDR_W - SECT_W;
  localparam int NSECT = 1 << IDX_W;

  // number of top sectors covered by a protection level
  function automatic logic [IDX_W:0] covered(input logic [2:0] lv);
    if (lv == 3'd0) return '0;
    if (int'(lv) - 1 >= IDX_W) return (IDX_W+1)'(NSECT);
    return (IDX_W+1)'(1) << (lv - 3'd1);
  endfunction

  logic [IDX_W:0] idx;
  assign idx = {1'b0, addr[ADDR_W-1:SECT_W]};
  assign sect_locked = idx >= ((IDX_W+1)'(NSECT) - covered(level));
  assign any_locked  = level != 3'd0;

  always_comb begin
    if (level == 3'd0)
      p_open_level_r5: assert (!sect_locked);
  end
endmodule

// File: rtl/fsg_timer.sv
module fsg_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= (load_val == '0) ? CNT_W'(1) : load_val;
    else if (cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  assign busy = cnt != '0;
  assign done = cnt == CNT_W'(1) && !load;

  p_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsg_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_wdata,
  input  logic              wp_n,
  input  logic [CNT_W-1:0]  busy_cycles,
  output logic              grant,
  output logic [7:0]        status
);
  fsg_op_e    op;
  logic       wel, lock;
  logic [2:0] level;
  logic       wip, done;
  logic       sect_locked, any_locked;
  logic       allowed, start, wstat_blocked;

  assign op = fsg_op_e'(cmd_op);

  fsg_zone #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_zone (
    .level(level), .addr(cmd_addr),
    .sect_locked(sect_locked), .any_locked(any_locked)
  );

  assign wstat_blocked = lock && !wp_n;

  always_comb begin
    unique case (op)
      OP_WEN, OP_WDIS: allowed = !wip;
      OP_RSTAT:        allowed = 1'b1;
      OP_WSTAT:        allowed = !wip && wel && !wstat_blocked;
      OP_PROG, OP_SERA: allowed = !wip && wel && !sect_locked;
      OP_BERA:         allowed = !wip && wel && !any_locked;
      default:         allowed = 1'b0;
    endcase
  end

  assign grant = cmd_valid && allowed;
  assign start = grant && is_modify(op);

  fsg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .load_val(busy_cycles),
    .busy(wip), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel   <= 1'b0;
      lock  <= 1'b0;
      level <= 3'd0;
    end else begin
      if (done) wel <= 1'b0;
      if (grant) begin
        if (op == OP_WEN)  wel <= 1'b1;
        if (op == OP_WDIS) wel <= 1'b0;
        if (op == OP_WSTAT) begin
          level <= cmd_wdata[4:2];
          lock  <= cmd_wdata[7];
        end
      end
    end
  end

  assign status = {lock, 2'b00, level, wel, wip};

  p_modify_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_modify(op) && !wel) |-> !grant);
  p_wp_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_WSTAT && lock && !wp_n) |=> ($stable(level) && $stable(lock)));
  p_busy_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> ($stable(level) && $stable(lock)));
  p_done_clears_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!wel && !wip));
  p_bulk_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_BERA && level != 3'd0) |-> !grant);
endmodule

// File: tb/sim_flash_status_guard.sv
module sim_flash_status_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [18:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        wp_n = 1'b1;
  logic [15:0] busy_cycles = 16'd1;
  logic        grant;
  logic [7:0]  status;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  flash_status_guard u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
    .busy_cycles(busy_cycles), .grant(grant), .status(status)
  );

  // op, addr, wdata, wp_n, expected grant, expected status after one idle cycle
  typedef struct packed {
    logic [2:0]  op;
    logic [18:0] addr;
    logic [7:0]  wd;
    logic        wp;
    logic        g;
    logic [7:0]  st;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VT [NV] = '{
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h02}, // R2 set latch
    '{3'd2, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h00}, // R2 clear latch
    '{3'd5, 19'h00000, 8'h00, 1'b1, 1'b0, 8'h00}, // R4 program no latch
    '{3'd4, 19'h00000, 8'hFF, 1'b1, 1'b0, 8'h00}, // R4 status write no latch
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h02},
    '{3'd4, 19'h00000, 8'h04, 1'b1, 1'b1, 8'h04}, // R3 level 1
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h06},
    '{3'd5, 19'h7FFFF, 8'h00, 1'b1, 1'b0, 8'h06}, // R7 sector 7 locked
    '{3'd6, 19'h60000, 8'h00, 1'b1, 1'b1, 8'h04}, // R5 sector 6 open at level 1
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h06},
    '{3'd7, 19'h00000, 8'h00, 1'b1, 1'b0, 8'h06}, // R8 bulk refused
    '{3'd4, 19'h00000, 8'h88, 1'b1, 1'b1, 8'h88}, // R3 lock + level 2
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h8A},
    '{3'd6, 19'h60000, 8'h00, 1'b1, 1'b0, 8'h8A}, // R5 sector 6 locked at 2
    '{3'd5, 19'h5FFFF, 8'h00, 1'b1, 1'b1, 8'h88}, // R7 sector 5 open
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h8A},
    '{3'd4, 19'h00000, 8'h00, 1'b0, 1'b0, 8'h8A}, // R6 pin low refuses
    '{3'd4, 19'h00000, 8'h63, 1'b1, 1'b1, 8'h00}, // R6/R3 pin high, junk bits
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h02},
    '{3'd7, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h00}, // R8 bulk at level 0
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h02},
    '{3'd4, 19'h00000, 8'h0C, 1'b1, 1'b1, 8'h0C}, // level 3
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h0E},
    '{3'd6, 19'h3FFFF, 8'h00, 1'b1, 1'b1, 8'h0C}, // R5 sector 3 open at 3
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h0E},
    '{3'd5, 19'h40000, 8'h00, 1'b1, 1'b0, 8'h0E}, // R5 sector 4 locked at 3
    '{3'd4, 19'h00000, 8'h10, 1'b1, 1'b1, 8'h10}, // level 4
    '{3'd1, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h12},
    '{3'd5, 19'h00000, 8'h00, 1'b1, 1'b0, 8'h12}, // R5 sector 0 locked at 4
    '{3'd3, 19'h00000, 8'h00, 1'b1, 1'b1, 8'h12}, // status read
    '{3'd0, 19'h00000, 8'h00, 1'b1, 1'b0, 8'h12}  // R2 code 0 not granted
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [18:0] a,
                       input logic [7:0] wd, input logic wp);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd; wp_n = wp;
  endtask

  task automatic idle();
    cmd_valid = 1'b0; cmd_op = 3'd0; wp_n = 1'b1;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", status, 8'h00);

    // table walk, one-cycle write time
    for (int i = 0; i < NV; i++) begin
      drive(VT[i].op, VT[i].addr, VT[i].wd, VT[i].wp);
      #1;
      check($sformatf("R11 grant vec %0d", i), {7'd0, grant}, {7'd0, VT[i].g});
      @(negedge clk);
      idle();
      @(negedge clk);
      check($sformatf("R4/R5 status vec %0d", i), status, VT[i].st);
    end

    // R9 R10: long write time, commands during busy
    drive(3'd2, '0, 8'h00, 1'b1); @(negedge clk);
    drive(3'd1, '0, 8'h00, 1'b1); @(negedge clk);
    busy_cycles = 16'd5;
    drive(3'd4, '0, 8'h00, 1'b1); @(negedge clk);      // accept edge E0
    check("R9 busy after accept", status, 8'h03);
    drive(3'd4, '0, 8'h1C, 1'b1); #1;
    check("R10 status write busy", {7'd0, grant}, 8'h00);
    @(negedge clk);                                      // E1
    drive(3'd2, '0, 8'h00, 1'b1); #1;
    check("R10 write disable busy", {7'd0, grant}, 8'h00);
    @(negedge clk);                                      // E2
    drive(3'd3, '0, 8'h00, 1'b1); #1;
    check("R10 status read busy", {7'd0, grant}, 8'h01);
    @(negedge clk);                                      // E3
    idle(); @(negedge clk);                              // E4
    check("R10 R9 still busy", status, 8'h03);
    @(negedge clk);                                      // E5
    check("R9 busy and latch drop", status, 8'h00);

    // R9: zero write time behaves as one
    busy_cycles = 16'd0;
    drive(3'd1, '0, 8'h00, 1'b1); @(negedge clk);
    drive(3'd5, 19'h12345, 8'h00, 1'b1); @(negedge clk);
    idle();
    check("R9 zero count busy", status, 8'h03);
    @(negedge clk);
    check("R9 zero count ends", status, 8'h00);

    // R1: reset mid-state
    busy_cycles = 16'd1;
    drive(3'd1, '0, 8'h00, 1'b1); @(negedge clk);
    drive(3'd4, '0, 8'h9C, 1'b1); @(negedge clk);
    idle();
    rst_n = 1'b0; #1;
    check("R1 async reset", status, 8'h00);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule